// File: doc/BRIEF.md
# USB Start-of-Frame Tracker

This block follows the Start-of-Frame tokens that a USB device receives from its host. Upstream logic decodes each token and presents a one-cycle strobe with the 11-bit frame number. On every strobe, the tracker stores the number, raises a sticky interrupt flag and emits a frame tick.

Once the first token has arrived, the host is expected to send one every millisecond. A local interval counter measures the gap since the most recent token. If the gap reaches a timeout slightly longer than one millisecond, the tracker declares the token lost. It then emits a substitute frame tick and a one-cycle missed indication, and it leaves the stored frame number untouched. The counter restarts after every token and after every declared loss, so the tick train keeps running through losses and falls back in step with the host as soon as a real token arrives.

The timeout length is derived from the `CLK_HZ` parameter and rounded up to whole clock cycles.

Top module: `sof_frame_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `frame_num` is 0 and `sof_irq`, `frame_tick`, `sof_missed` and `locked` are all low.
- R2: A cycle with `sof_stb` high loads `sof_frame` (all 11 bits) into `frame_num`, which shows the value from the next cycle on.
- R3: A cycle with `sof_stb` high sets `sof_irq` from the next cycle; the flag then stays high while neither `irq_clr` nor `sof_stb` is asserted.
- R4: A cycle with `irq_clr` high and `sof_stb` low clears `sof_irq` for the next cycle; when both are high in the same cycle, `sof_irq` is high in the next cycle.
- R5: Until the first `sof_stb` after reset, `locked`, `sof_missed` and `frame_tick` stay low however long the wait; the first `sof_stb` raises `locked` in the next cycle, and it then stays high until reset.
- R6: With T = ceil(CLK_HZ × 100358 / 10^8) clock cycles, if `sof_stb` was high in cycle k and has been low since, `sof_missed` and `frame_tick` are high for exactly the one cycle k+T+1 and low in cycles k+1..k+T (except for the tick in cycle k+1). A loss changes neither `frame_num` nor `sof_irq`.
- R7: After a declared loss, with no new token, the next loss is declared T cycles later, and so on at every T cycles.
- R8: Any `sof_stb` restarts the interval: the next loss is counted from that strobe. A strobe in the very cycle the timeout would expire suppresses that loss, so `sof_missed` stays low in the following cycle.
- R9: `frame_tick` is high in the cycle after every `sof_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sof_stb | input | 1 | One-cycle strobe: a valid Start-of-Frame token was received |
| sof_frame | input | 11 | Frame number carried by the token, valid with `sof_stb` |
| irq_clr | input | 1 | Write strobe clearing the interrupt flag |
| frame_num | output | 11 | Frame number of the most recently received token |
| sof_irq | output | 1 | Sticky Start-of-Frame interrupt flag |
| frame_tick | output | 1 | One-cycle frame pulse for a real or a substituted frame |
| sof_missed | output | 1 | One-cycle pulse: an expected token did not arrive in time |
| locked | output | 1 | A token has been seen since reset |

## Verification
Two pairs of functions can land in one cycle. The first pair is a token strobe and an interrupt clear, driven together in a vector of the stimulus table; the flag must read high afterwards. The second pair is a token and the timeout expiry. The bench counts T−1 quiet cycles after a token, presents the next token exactly on the expiry cycle, and requires that no missed pulse appears, that the tick still comes, and that the next loss is measured from the new token.

// File: rtl/sof_trk_pkg.sv
// Package: shared constants and the timeout computation for the SOF tracker.
// Assumes the nominal frame interval plus tolerance is 1.00358 ms.
package sof_trk_pkg;

    localparam int FRAME_W = 11;

    // Timeout in units of 10 ns over 1e8 (1.00358 ms = 100358 / 1e8 s).
    localparam longint unsigned TMO_NUM = 64'd100358;
    localparam longint unsigned TMO_DEN = 64'd100_000_000;

    // Timeout length in clock cycles, rounded up.
    function automatic longint unsigned timeout_cycles(input longint unsigned clk_hz);
        return (clk_hz * TMO_NUM + TMO_DEN - 64'd1) / TMO_DEN;
    endfunction

endpackage

// File: rtl/sof_frame_latch.sv
// Module: holds the frame number of the last received token.
// Assumes sof_stb is a single-cycle strobe qualified upstream.
module sof_frame_latch #(
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof_stb,
    input  logic [FRAME_W-1:0] sof_frame,
    output logic [FRAME_W-1:0] frame_q
);

    // Load the frame number on each token, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_q <= '0;
        else if (sof_stb)
            frame_q <= sof_frame;
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sof_stb |=> frame_q == $past(sof_frame));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_stb |=> $stable(frame_q));

endmodule

// File: rtl/sof_irq_flag.sv
// Module: sticky interrupt flag, set by a token, cleared by a write strobe.
// Assumes a set and a clear in the same cycle resolve to set.
module sof_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);

    // Set has priority over clear; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_q));

endmodule

// File: rtl/sof_interval_timer.sv
// Module: measures the gap since the last token, declares a loss at the
// timeout, and generates the frame tick for real and substituted frames.
// Assumes TMO_CYC >= 2. Idle until the first token after reset.
module sof_interval_timer #(
    parameter int unsigned TMO_CYC = 125448
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_stb,
    output logic locked_q,
    output logic miss_q,
    output logic tick_q
);

    localparam int CNT_W = $clog2(TMO_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    // Timeout fires only while locked and when no token arrives this cycle.
    always_comb begin
        expire = locked_q && !sof_stb && (cnt_q == LAST);
    end

    // Lock on the first token and keep it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_q <= 1'b0;
        else if (sof_stb)
            locked_q <= 1'b1;
    end

    // Interval counter: restart on a token or a timeout, count while locked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (sof_stb || expire)
            cnt_q <= '0;
        else if (locked_q)
            cnt_q <= cnt_q + 1'b1;
    end

    // Register the loss pulse and the merged frame tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_q <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            miss_q <= expire;
            tick_q <= sof_stb || expire;
        end
    end

    p_idle_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_q |-> (cnt_q == '0) && !miss_q);

    p_miss_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q |=> !miss_q);

    p_miss_ticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q |-> tick_q);

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q |-> cnt_q <= CNT_W'(1));

    p_sof_no_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sof_stb |=> !miss_q);

endmodule

// File: rtl/sof_frame_tracker.sv
// Module: top of the SOF tracker. Stores the frame number, keeps the sticky
// interrupt flag and runs the loss timer. Assumes tokens are already decoded
// and CRC-checked; CLK_HZ is the frequency of clk.
module sof_frame_tracker #(
    parameter longint unsigned CLK_HZ = 125_000_000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             sof_stb,
    input  logic [sof_trk_pkg::FRAME_W-1:0]  sof_frame,
    input  logic                             irq_clr,
    output logic [sof_trk_pkg::FRAME_W-1:0]  frame_num,
    output logic                             sof_irq,
    output logic                             frame_tick,
    output logic                             sof_missed,
    output logic                             locked
);

    localparam int unsigned TMO_CYC = 32'(sof_trk_pkg::timeout_cycles(CLK_HZ));

    sof_frame_latch #(
        .FRAME_W (sof_trk_pkg::FRAME_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof_stb   (sof_stb),
        .sof_frame (sof_frame),
        .frame_q   (frame_num)
    );

    sof_irq_flag u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sof_stb),
        .clr_i  (irq_clr),
        .flag_q (sof_irq)
    );

    sof_interval_timer #(
        .TMO_CYC (TMO_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof_stb  (sof_stb),
        .locked_q (locked),
        .miss_q   (sof_missed),
        .tick_q   (frame_tick)
    );

    p_tick_on_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sof_stb |=> frame_tick);

    p_loss_keeps_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof_stb && !irq_clr) |=> $stable(sof_irq));

endmodule

// File: tb/tb_sof_frame_tracker.sv
`timescale 1ns/1ps
module tb_sof_frame_tracker;

    localparam longint unsigned CLK_HZ = 100_000;
    // R6 timeout: ceil(CLK_HZ * 100358 / 1e8) cycles.
    localparam longint unsigned TL = (CLK_HZ * 64'd100358 + 64'd99_999_999) / 64'd100_000_000;
    localparam int T = int'(TL);

    typedef struct packed {
        logic        sof;
        logic [10:0] fr;
        logic        clr;
        logic [10:0] e_frame;
        logic        e_irq;
        logic        e_tick;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 11'h123, 1'b0, 11'h123, 1'b1, 1'b1},
        '{1'b0, 11'h3C3, 1'b0, 11'h123, 1'b1, 1'b0},
        '{1'b0, 11'h000, 1'b1, 11'h123, 1'b0, 1'b0},
        '{1'b1, 11'h7FF, 1'b1, 11'h7FF, 1'b1, 1'b1},
        '{1'b1, 11'h000, 1'b0, 11'h000, 1'b1, 1'b1},
        '{1'b0, 11'h555, 1'b1, 11'h000, 1'b0, 1'b0},
        '{1'b1, 11'h555, 1'b0, 11'h555, 1'b1, 1'b1},
        '{1'b0, 11'h2AA, 1'b0, 11'h555, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_stb = 1'b0;
    logic [10:0] sof_frame = '0;
    logic        irq_clr = 1'b0;
    logic [10:0] frame_num;
    logic        sof_irq, frame_tick, sof_missed, locked;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sof_frame_tracker #(.CLK_HZ(CLK_HZ)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_stb    (sof_stb),
        .sof_frame  (sof_frame),
        .irq_clr    (irq_clr),
        .frame_num  (frame_num),
        .sof_irq    (sof_irq),
        .frame_tick (frame_tick),
        .sof_missed (sof_missed),
        .locked     (locked)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock cycle with the given inputs; returns 1 ns after the edge.
    task automatic cyc(input logic s, input logic [10:0] f, input logic c);
        sof_stb = s; sof_frame = f; irq_clr = c;
        @(posedge clk); #1;
        sof_stb = 1'b0; irq_clr = 1'b0;
    endtask

    // Idle for n cycles, expecting a loss only on the last one.
    task automatic wait_loss(input int n, input string req, input logic [10:0] fr_exp);
        int first_bad;
        first_bad = -1;
        for (int j = 1; j <= n; j++) begin
            cyc(1'b0, 11'h0, 1'b0);
            if (j < n && (sof_missed || frame_tick) && first_bad < 0) first_bad = j;
        end
        chk({req, " no early loss"}, first_bad, -1);
        chk({req, " missed pulse"}, int'(sof_missed), 1);
        chk({req, " substitute tick"}, int'(frame_tick), 1);
        chk({req, " frame kept"}, int'(frame_num), int'(fr_exp));
        cyc(1'b0, 11'h0, 1'b0);
        chk({req, " missed one cycle"}, int'(sof_missed), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 frame", int'(frame_num), 0);
        chk("R1 irq", int'(sof_irq), 0);
        chk("R1 tick", int'(frame_tick), 0);
        chk("R1 missed", int'(sof_missed), 0);
        chk("R1 locked", int'(locked), 0);
        rst_n = 1'b1;

        // R5: long idle before first token
        begin
            int seen;
            seen = 0;
            for (int j = 0; j < 3 * T; j++) begin
                cyc(1'b0, 11'h0, 1'b0);
                if (sof_missed || frame_tick || locked) seen++;
            end
            chk("R5 idle before lock", seen, 0);
        end

        // Vector table: R2, R3, R4, R9
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].sof, VEC[i].fr, VEC[i].clr);
            chk("R2 frame vec", int'(frame_num), int'(VEC[i].e_frame));
            chk("R3/R4 irq vec", int'(sof_irq), int'(VEC[i].e_irq));
            chk("R9 tick vec", int'(frame_tick), int'(VEC[i].e_tick));
            chk("R6 no loss vec", int'(sof_missed), 0);
            if (i == 0) chk("R5 locked after first token", int'(locked), 1);
        end

        // R6: loss after T cycles; irq was cleared, stays clear
        cyc(1'b1, 11'h0AA, 1'b0);
        cyc(1'b0, 11'h0, 1'b1);
        chk("R4 clear", int'(sof_irq), 0);
        wait_loss(T - 1, "R6", 11'h0AA);
        chk("R6 irq untouched", int'(sof_irq), 0);
        // R7: next loss T cycles after previous (one cycle already spent)
        wait_loss(T - 1, "R7", 11'h0AA);
        chk("R5 still locked", int'(locked), 1);

        // R8: token mid-interval restarts the count
        for (int j = 0; j < 40; j++) cyc(1'b0, 11'h0, 1'b0);
        cyc(1'b1, 11'h0BB, 1'b0);
        wait_loss(T, "R8 restart", 11'h0BB);

        // R8: token exactly on the expiry cycle suppresses the loss
        cyc(1'b1, 11'h0CC, 1'b0);
        for (int j = 0; j < T - 1; j++) cyc(1'b0, 11'h0, 1'b0);
        cyc(1'b1, 11'h0DD, 1'b0);
        chk("R8 coincident no miss", int'(sof_missed), 0);
        chk("R9 coincident tick", int'(frame_tick), 1);
        chk("R2 coincident frame", int'(frame_num), 'h0DD);
        wait_loss(T, "R8 after coincide", 11'h0DD);

        // R1: reset mid-run
        rst_n = 1'b0;
        cyc(1'b0, 11'h0, 1'b0);
        chk("R1 relock cleared", int'(locked), 0);
        chk("R1 frame cleared", int'(frame_num), 0);
        chk("R1 irq cleared", int'(sof_irq), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule